// File: doc/BRIEF.md
# SDRAM Burst Cut-Off and Auto-Precharge Tracker

This block follows the data burst on each bank of an SDR SDRAM device, cycle by cycle, as seen by a controller or a behavioural bank model. Every READ or WRITE the controller registers is fed in together with its bank number, its auto-precharge flag and the data mask the controller drove. From that, the tracker works out which bank owns the data bus, when read data is valid, and when write data is being captured. A new READ or WRITE to a different bank cuts the running burst short. The cut-off point depends on the direction of both the old and the new command.

When the cut-off burst had auto precharge set, the interrupted bank begins its own precharge without a further command. A read starts precharging on the cut-off edge. A write first waits out the write-recovery time, counted from the cut-off edge. Bursts that run to their full length schedule their precharge in the usual way. The tracker also reports how many cycles of data masking a WRITE needs ahead of it while read data is still pending. An assertion flags any controller that issues a WRITE without that mask.

Top module: `sdr_burst_tracker`

## Requirements
- R1: After reset, `bank_active`, `pre_start`, `rd_valid`, `wr_valid` and `dqm_lead` are all zero.
- R2: A READ registered at edge t0 sets `bank_active[b]` for the BURST_LEN cycles after edges t0..t0+BURST_LEN-1. It sets `rd_valid` for the cycles after edges t0+CAS_LAT..t0+CAS_LAT+BURST_LEN-1.
- R3: A WRITE registered at edge t0 captures one word per edge from t0 on. `wr_valid` and `bank_active[b]` are high for the cycles after edges t0..t0+BURST_LEN-1.
- R4: A READ cut off by a READ to another bank at edge t1 keeps delivering its data up to edge t1+CAS_LAT-1, and the new data follows at once. `rd_valid` has no gap, and the old bank's `bank_active` drops after edge t1.
- R5: A READ cut off by a WRITE at edge t1 ends at t1. All of its undelivered read data is discarded, so `rd_valid` is low from the cycle after t1 on, and the new write's `wr_valid` starts there.
- R6: A WRITE cut off at edge t1 took its last word at edge t1-1. A following WRITE continues `wr_valid` without a gap. A following READ ends `wr_valid` after t1 and raises `rd_valid` after t1+CAS_LAT.
- R7: `dqm_lead` is 0 when no read data is pending, 1 when it is and the most recent READ had no auto precharge, and 2 when it had. A WRITE registered while `dqm_lead` is nonzero must have had `dqm_in` high on that many preceding edges.
- R8: A READ with auto precharge cut off at edge t1 gives a one-cycle `pre_start[b]` pulse in the cycle after t1.
- R9: A WRITE with auto precharge cut off at edge t1 gives its `pre_start[b]` pulse in the cycle after edge t1+T_WR.
- R10: A READ with auto precharge that runs its full length gives its `pre_start[b]` pulse in the cycle after edge t0+BURST_LEN.
- R11: A WRITE with auto precharge that runs its full length gives its `pre_start[b]` pulse in the cycle after edge t0+BURST_LEN-1+T_WR, that is T_WR after the last word.
- R12: A burst without auto precharge never produces a `pre_start` pulse, whether it ends naturally or is cut off.
- R13: `rd_valid` and `wr_valid` are never high together, and at most one bit of `bank_active` is set.
- R14: The auto-precharge flag of the interrupting command has no effect on where the old burst is cut off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A READ or WRITE is registered on this edge |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| cmd_ap | input | 1 | Auto precharge requested with the command |
| dqm_in | input | 1 | Data mask the controller drives on this edge |
| bank_active | output | NUM_BANKS | Bank owns a running burst |
| rd_valid | output | 1 | Read data word is on the bus this cycle |
| wr_valid | output | 1 | Write data word was captured on the edge that started this cycle |
| dqm_lead | output | 2 | Mask cycles a WRITE issued now needs before it |
| pre_start | output | NUM_BANKS | One-cycle pulse: bank begins auto precharge |

## Verification
The hardest case to reach from the ports is a cut-off that happens while read data is still in the CAS-latency pipeline. The case is hardest when an auto-precharged write is also waiting out its recovery time, because the two timers interleave. Each directed scenario therefore issues a first command and then a second command to another bank, a chosen number of edges later. It records every output per cycle and compares the whole trace against timelines worked out from the requirements. The scenarios cover each read/write pairing with and without auto precharge. Before each second command the bench raises the data mask for two edges, so the mask rule can be checked on every read-to-write cut-off.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
   typedef enum logic [1:0] {
      BK_IDLE  = 2'd0,
      BK_READ  = 2'd1,
      BK_WRITE = 2'd2,
      BK_WRREC = 2'd3
   } bank_st_e;
endpackage

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
   import sdr_burst_pkg::*;
#(
   parameter int BURST_LEN = 4,
   parameter int T_WR      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic cut_i,
   input  logic cmd_write_i,
   input  logic cmd_ap_i,
   output logic reading_o,
   output logic writing_o,
   output logic pre_start_o
);
   localparam int REM_W = $clog2(BURST_LEN + 1);
   localparam int TWR_W = $clog2(T_WR + 1);

   bank_st_e           st_q;
   logic [REM_W-1:0]   rem_q;
   logic [TWR_W-1:0]   twr_q;
   logic               ap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= BK_IDLE;
         rem_q       <= '0;
         twr_q       <= '0;
         ap_q        <= 1'b0;
         pre_start_o <= 1'b0;
      end else begin
         pre_start_o <= 1'b0;
         if (sel_i) begin
            st_q  <= cmd_write_i ? BK_WRITE : BK_READ;
            rem_q <= REM_W'(BURST_LEN);
            ap_q  <= cmd_ap_i;
         end else begin
            unique case (st_q)
               BK_READ: begin
                  if (cut_i || rem_q == REM_W'(1)) begin
                     pre_start_o <= ap_q;
                     st_q        <= BK_IDLE;
                  end else begin
                     rem_q <= rem_q - REM_W'(1);
                  end
               end
               BK_WRITE: begin
                  if (rem_q == REM_W'(1)) begin
                     if (ap_q && T_WR == 1) begin
                        pre_start_o <= 1'b1;
                        st_q        <= BK_IDLE;
                     end else if (ap_q) begin
                        st_q  <= BK_WRREC;
                        twr_q <= TWR_W'(T_WR - 1);
                     end else begin
                        st_q <= BK_IDLE;
                     end
                  end else if (cut_i) begin
                     if (ap_q) begin
                        st_q  <= BK_WRREC;
                        twr_q <= TWR_W'(T_WR);
                     end else begin
                        st_q <= BK_IDLE;
                     end
                  end else begin
                     rem_q <= rem_q - REM_W'(1);
                  end
               end
               BK_WRREC: begin
                  if (twr_q == TWR_W'(1)) begin
                     pre_start_o <= 1'b1;
                     st_q        <= BK_IDLE;
                  end else begin
                     twr_q <= twr_q - TWR_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reading_o = (st_q == BK_READ);
   assign writing_o = (st_q == BK_WRITE);

   // R8: an auto-precharged read that is cut off precharges on the next cycle
   p_rdap_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_READ && ap_q && cut_i && !sel_i) |=> pre_start_o);

   // R9: an auto-precharged write that is cut off must wait for recovery first
   p_wrap_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_WRITE && ap_q && cut_i && !sel_i && rem_q != REM_W'(1))
      |=> !pre_start_o);
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
   parameter int CAS_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   input  logic flush_i,
   output logic valid_o,
   output logic pending_o
);
   logic [CAS_LAT-1:0] slot_q;

   generate
      if (CAS_LAT == 2) begin : g_short
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot_q <= '0;
            else if (flush_i) slot_q <= '0;
            else              slot_q <= {slot_q[0], issue_i};
         end
      end else begin : g_long
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot_q <= '0;
            else if (flush_i) slot_q <= '0;
            else              slot_q <= {slot_q[CAS_LAT-2:0], issue_i};
         end
      end
   endgenerate

   assign valid_o   = slot_q[CAS_LAT-1];
   assign pending_o = issue_i | (|slot_q);

   // R5: read data scheduled before a WRITE is never delivered after it
   p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !valid_o);
endmodule

// File: rtl/sdr_burst_tracker.sv
module sdr_burst_tracker #(
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   parameter int CAS_LAT   = 2,
   parameter int T_WR      = 2,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_write,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic                 dqm_in,
   output logic [NUM_BANKS-1:0] bank_active,
   output logic                 rd_valid,
   output logic                 wr_valid,
   output logic [1:0]           dqm_lead,
   output logic [NUM_BANKS-1:0] pre_start
);
   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (!(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
         $error("BURST_LEN must be 1, 2, 4 or 8");
      end
      if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_cl
         $error("CAS_LAT must be 2 or 3");
      end
      if (T_WR < 1) begin : g_bad_twr
         $error("T_WR must be at least 1");
      end
   endgenerate

   logic [NUM_BANKS-1:0] rd_st;
   logic [NUM_BANKS-1:0] wr_st;
   logic                 rd_pend;
   logic                 last_rd_ap_q;
   logic                 wr_cmd;

   assign wr_cmd = cmd_valid & cmd_write;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = cmd_valid && (cmd_bank == BANK_W'(b));
      sdr_bank_fsm #(
         .BURST_LEN (BURST_LEN),
         .T_WR      (T_WR)
      ) bank_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .sel_i       (sel),
         .cut_i       (cmd_valid),
         .cmd_write_i (cmd_write),
         .cmd_ap_i    (cmd_ap),
         .reading_o   (rd_st[b]),
         .writing_o   (wr_st[b]),
         .pre_start_o (pre_start[b])
      );
   end

   sdr_rd_pipe #(
      .CAS_LAT (CAS_LAT)
   ) rd_pipe_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_i   (|rd_st),
      .flush_i   (wr_cmd),
      .valid_o   (rd_valid),
      .pending_o (rd_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      last_rd_ap_q <= 1'b0;
      else if (cmd_valid && !cmd_write) last_rd_ap_q <= cmd_ap;
   end

   assign bank_active = rd_st | wr_st;
   assign wr_valid    = |wr_st;
   assign dqm_lead    = !rd_pend ? 2'd0 : (last_rd_ap_q ? 2'd2 : 2'd1);

   // R7: a WRITE over pending read data needs the mask on the edge before
   p_dqm_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && dqm_lead != 2'd0) |-> $past(dqm_in));

   // R7: after an auto-precharged read the mask is needed two edges ahead
   p_dqm_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && dqm_lead == 2'd2) |-> $past(dqm_in, 2));

   // R13: the data bus is never driven in both directions
   p_bus_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid));

   // R13: only one bank owns a burst at a time
   p_one_burst_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_active));
endmodule

// File: tb/sdr_burst_tracker_tb.sv
module sdr_burst_tracker_tb_top;
   localparam int NB  = 4;
   localparam int BL  = 4;
   localparam int CL  = 2;
   localparam int TWR = 2;
   localparam int N   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_write = 1'b0;
   logic [1:0]    cmd_bank = '0;
   logic          cmd_ap = 1'b0;
   logic          dqm_in = 1'b0;
   logic [NB-1:0] bank_active;
   logic          rd_valid;
   logic          wr_valid;
   logic [1:0]    dqm_lead;
   logic [NB-1:0] pre_start;

   int n_chk = 0;
   int n_err = 0;

   logic          rdv [N];
   logic          wrv [N];
   logic [NB-1:0] act [N];
   logic [NB-1:0] pre [N];
   logic [1:0]    dql [N];

   always #2 clk = ~clk;

   sdr_burst_tracker #(
      .NUM_BANKS (NB), .BURST_LEN (BL), .CAS_LAT (CL), .T_WR (TWR)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_write (cmd_write),
      .cmd_bank (cmd_bank), .cmd_ap (cmd_ap), .dqm_in (dqm_in),
      .bank_active (bank_active), .rd_valid (rd_valid), .wr_valid (wr_valid),
      .dqm_lead (dqm_lead), .pre_start (pre_start)
   );

   task automatic chk(input string req, input int act_v, input int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // first command at edge t0 (k=0), optional second at edge t0+gap; k = cycle after edge t0+k
   task automatic run_pair(input bit w1, input bit a1, input int b1,
                           input bit w2, input bit a2, input int b2, input int gap);
      for (int k = 0; k < N; k++) begin
         cmd_valid = 1'b0;
         if (k == 0) begin
            cmd_valid = 1'b1; cmd_write = w1; cmd_ap = a1; cmd_bank = 2'(b1);
         end else if (gap > 0 && k == gap) begin
            cmd_valid = 1'b1; cmd_write = w2; cmd_ap = a2; cmd_bank = 2'(b2);
         end
         dqm_in = (gap > 0) && (k == gap - 1 || k == gap - 2);
         step();
         rdv[k] = rd_valid; wrv[k] = wr_valid; act[k] = bank_active;
         pre[k] = pre_start; dql[k] = dqm_lead;
         chk("R13 bus direction", int'(rd_valid && wr_valid), 0);
         chk("R13 single burst", int'($countones(bank_active) <= 1), 1);
      end
      cmd_valid = 1'b0; dqm_in = 1'b0;
      repeat (4) step();
   endtask

   function automatic logic [NB-1:0] onehot_if(input bit c, input int b);
      return c ? NB'(1 << b) : '0;
   endfunction

   task automatic t_reset();
      chk("R1 bank_active", int'(bank_active), 0);
      chk("R1 pre_start", int'(pre_start), 0);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 wr_valid", int'(wr_valid), 0);
      chk("R1 dqm_lead", int'(dqm_lead), 0);
   endtask

   task automatic t_read_plain();
      run_pair(0, 0, 1, 0, 0, 0, 0);
      for (int k = 0; k < N; k++) begin
         chk("R2 rd_valid", int'(rdv[k]), int'(k >= CL && k < CL + BL));
         chk("R2 bank_active", int'(act[k]), int'(onehot_if(k < BL, 1)));
         chk("R12 no precharge", int'(pre[k]), 0);
      end
      chk("R7 lead no-ap", int'(dql[0]), 1);
      chk("R7 lead drained", int'(dql[CL + BL]), 0);
   endtask

   task automatic t_write_ap();
      run_pair(1, 1, 2, 0, 0, 0, 0);
      for (int k = 0; k < N; k++) begin
         chk("R3 wr_valid", int'(wrv[k]), int'(k < BL));
         chk("R3 bank_active", int'(act[k]), int'(onehot_if(k < BL, 2)));
         chk("R11 write ap natural", int'(pre[k]), int'(onehot_if(k == BL - 1 + TWR, 2)));
      end
      chk("R7 lead after write", int'(dql[0]), 0);
   endtask

   task automatic t_read_ap();
      run_pair(0, 1, 0, 0, 0, 0, 0);
      for (int k = 0; k < N; k++)
         chk("R10 read ap natural", int'(pre[k]), int'(onehot_if(k == BL, 0)));
      chk("R7 lead with ap", int'(dql[0]), 2);
   endtask

   task automatic t_rd_rd();
      run_pair(0, 0, 0, 0, 1, 3, 2);
      for (int k = 0; k < N; k++) begin
         chk("R4 seamless rd_valid", int'(rdv[k]), int'(k >= CL && k < 2 + CL + BL));
         chk("R4 R14 bank_active", int'(act[k]),
             int'(onehot_if(k < 2, 0) | onehot_if(k >= 2 && k < 2 + BL, 3)));
         chk("R12 R10 precharge", int'(pre[k]), int'(onehot_if(k == 2 + BL, 3)));
      end
   endtask

   task automatic t_rdap_wr();
      run_pair(0, 1, 1, 1, 0, 2, 2);
      for (int k = 0; k < N; k++) begin
         chk("R5 rd_valid discarded", int'(rdv[k]), 0);
         chk("R5 wr_valid", int'(wrv[k]), int'(k >= 2 && k < 2 + BL));
         chk("R8 read ap cut", int'(pre[k]), int'(onehot_if(k == 2, 1)));
      end
      chk("R7 lead before write", int'(dql[1]), 2);
   endtask

   task automatic t_wrap_rd();
      run_pair(1, 1, 3, 0, 1, 0, 2);
      for (int k = 0; k < N; k++) begin
         chk("R6 wr_valid ends", int'(wrv[k]), int'(k < 2));
         chk("R6 rd_valid", int'(rdv[k]), int'(k >= 2 + CL && k < 2 + CL + BL));
         chk("R9 write ap cut", int'(pre[k]),
             int'(onehot_if(k == 2 + TWR, 3) | onehot_if(k == 2 + BL, 0)));
      end
   endtask

   task automatic t_wr_wrap();
      run_pair(1, 0, 0, 1, 1, 1, 3);
      for (int k = 0; k < N; k++) begin
         chk("R6 wr_valid seamless", int'(wrv[k]), int'(k < 3 + BL));
         chk("R6 R14 bank_active", int'(act[k]),
             int'(onehot_if(k < 3, 0) | onehot_if(k >= 3 && k < 3 + BL, 1)));
         chk("R12 R11 precharge", int'(pre[k]), int'(onehot_if(k == 3 + BL - 1 + TWR, 1)));
      end
   endtask

   task automatic t_rd_wr_quick();
      run_pair(0, 0, 2, 1, 1, 0, 1);
      chk("R7 lead no-ap at cut", int'(dql[0]), 1);
      for (int k = 0; k < N; k++) begin
         chk("R5 rd_valid none", int'(rdv[k]), 0);
         chk("R12 R14 no precharge on cut bank", int'(pre[k][2]), 0);
      end
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_read_plain();
      t_write_ap();
      t_read_ap();
      t_rd_rd();
      t_rdap_wr();
      t_wrap_rd();
      t_wr_wrap();
      t_rd_wr_quick();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got 1 expected 0 (run hung)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule